// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a supervisory timer placed on a simple register bus. It counts ticks from one of several tick-enable inputs and raises a one-cycle reset request when the count equals a programmable timeout. Software keeps the system alive by writing an ordered pair of key words to the counter register. A different key pair opens the configuration registers for a short time. A sticky timeout flag records every reset request until software clears it.

After reset the configuration registers stay writable until control byte 0 is first written. From then on they accept writes only inside an unlock window. Software can open that window only if it set the reconfiguration-permit bit. An optional refresh window rejects refreshes that arrive too early. Clock generation, clock-domain crossing and the system reset controller are outside the block.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the reset request and the flag are low, and reads return 0x0 at offset 0x0, 0x0 at 0x4 (count), 0x1500 at 0x8 (timeout) and 0x0 at 0xC (window).
- R2: The count advances by one on a clock where control byte 0 bit 7 (enable) is set and the tick input selected by control byte 1 bits 1:0 is high. The select value is the tick input index: 0 bus, 1 low-power 1 kHz, 2 32 kHz, 3 external. Ticks on other inputs, or with enable clear, leave the count unchanged.
- R3: While enabled, a count equal to the timeout value makes the block raise the reset request for one clock on the next edge, set the flag and clear the count to zero on that same edge.
- R4: Word 0xA602 written to offset 0x4, followed by 0xB480 as the next write to 0x4, is a refresh. It clears the count on the edge of the second write.
- R5: A key pair is dropped if a different value is written to 0x4 between its two words, or if the second word comes more than 16 bus clocks after the first.
- R6: The flag reads at bit 14 of a word read at 0x0 (bit 6 of control byte 1). Writing 1 to that bit clears the flag, writing 0 leaves it set, and this works whether or not the registers are locked.
- R7: After reset, writes to control bytes 0 and 1 (clock select), the timeout register (0x8) and the window register (0xC) are accepted until control byte 0 is written. After that, writes to these registers are ignored unless an unlock window is open.
- R8: Word 0xC520 followed by 0xD928 at 0x4 opens the unlock window, but only if control byte 0 bit 5 (reconfiguration permit) is set. The window stays open for 128 bus clocks, or until control byte 0 is written, whichever comes first.
- R9: With a non-zero window value, a refresh that arrives while the enabled count is below the window value gives a one-clock reset request and sets the flag, and it does not clear the count. A refresh at or above the window value clears the count.
- R10: A window value of zero accepts a refresh at any count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Write strobe, one clock per write |
| busByte | input | 1 | 1: byte write at offset 0x0/0x1 using data bits 7:0; 0: 32-bit word write |
| busAddr | input | 4 | Byte offset of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| tickEn | input | NSRC | One tick-enable per clock source |
| rstReq | output | 1 | One-clock reset request |
| toFlag | output | 1 | Sticky timeout flag |

## Verification
On every cycle the assertions check four things. A reset request always comes with the flag. A timeout always clears the count and pulses the request on the next edge. The count stays still while the counter is disabled and no refresh arrives. A locked timeout register never changes. They also check that the flag stays set until it is cleared, and that a refresh with no window clears the count. Only the bench scenarios can show the rest: the exact key ordering, the 16-clock gap limit, the 128-clock unlock lifetime and its early close, the one-time configuration after reset, and early refreshes being rejected against the window.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;
  localparam logic [31:0] KEY_REF_A = 32'h0000_A602;
  localparam logic [31:0] KEY_REF_B = 32'h0000_B480;
  localparam logic [31:0] KEY_UNL_A = 32'h0000_C520;
  localparam logic [31:0] KEY_UNL_B = 32'h0000_D928;

  localparam logic [3:0] OFS_CTL  = 4'h0;
  localparam logic [3:0] OFS_CTL1 = 4'h1;
  localparam logic [3:0] OFS_CNT  = 4'h4;
  localparam logic [3:0] OFS_TOV  = 4'h8;
  localparam logic [3:0] OFS_WIN  = 4'hC;

  localparam int CTL_EN_BIT   = 7;
  localparam int CTL_PERM_BIT = 5;
  localparam int CTL1_FLG_BIT = 6;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_REF,
    SEQ_UNL
  } seq_e;

  typedef struct packed {
    logic refresh;
    logic flagClr;
  } ctrl_stb_t;
endpackage

// File: rtl/keyed_wdt_ctrl.sv
module keyed_wdt_ctrl
  import keyed_wdt_pkg::*;
#(
  parameter int DW          = 16,
  parameter int SEL_W       = 2,
  parameter int SEQ_GAP     = 16,
  parameter int OPEN_CYC    = 128,
  parameter logic [DW-1:0] DEF_TIMEOUT = 16'h1500
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWr,
  input  logic             busByte,
  input  logic [3:0]       busAddr,
  input  logic [31:0]      busWdata,
  output logic [7:0]       cs1Q,
  output logic [SEL_W-1:0] clkSelQ,
  output logic [DW-1:0]    tovQ,
  output logic [DW-1:0]    winQ,
  output logic             cfgOpen,
  output ctrl_stb_t        stb
);
  localparam int GAP_W  = $clog2(SEQ_GAP) + 1;
  localparam int OPEN_W = $clog2(OPEN_CYC + 1);
  localparam logic [GAP_W-1:0]  GAP_LAST = GAP_W'(SEQ_GAP - 1);
  localparam logic [OPEN_W-1:0] OPEN_LD  = OPEN_W'(OPEN_CYC);

  seq_e seqQ, seqNext;
  logic [GAP_W-1:0]  gapQ, gapNext;
  logic [OPEN_W-1:0] openQ;
  logic doneQ;
  logic refreshHit, unlockHit;

  logic wrCs1, wrCs2, wrCnt, wrTov, wrWin;
  logic [SEL_W-1:0] cs2Sel;
  logic cs2Clr;

  // Address decode: byte writes reach the two control bytes, word writes reach everything
  always_comb begin
    wrCs1 = busWr && (busAddr == OFS_CTL);
    wrCs2 = busWr && ((busByte && busAddr == OFS_CTL1) || (!busByte && busAddr == OFS_CTL));
    wrCnt = busWr && !busByte && (busAddr == OFS_CNT);
    wrTov = busWr && !busByte && (busAddr == OFS_TOV);
    wrWin = busWr && !busByte && (busAddr == OFS_WIN);
    cs2Sel = busByte ? busWdata[SEL_W-1:0] : busWdata[8 +: SEL_W];
    cs2Clr = busByte ? busWdata[CTL1_FLG_BIT] : busWdata[8 + CTL1_FLG_BIT];
  end

  // Key-pair detector shared by refresh and unlock
  always_comb begin
    seqNext    = seqQ;
    gapNext    = gapQ;
    refreshHit = 1'b0;
    unlockHit  = 1'b0;
    if (wrCnt) begin
      gapNext = '0;
      if (seqQ == SEQ_REF && busWdata == KEY_REF_B) begin
        refreshHit = 1'b1;
        seqNext    = SEQ_IDLE;
      end else if (seqQ == SEQ_UNL && busWdata == KEY_UNL_B) begin
        unlockHit = 1'b1;
        seqNext   = SEQ_IDLE;
      end else if (busWdata == KEY_REF_A) begin
        seqNext = SEQ_REF;
      end else if (busWdata == KEY_UNL_A) begin
        seqNext = SEQ_UNL;
      end else begin
        seqNext = SEQ_IDLE;
      end
    end else if (seqQ != SEQ_IDLE) begin
      if (gapQ == GAP_LAST) begin
        seqNext = SEQ_IDLE;
        gapNext = '0;
      end else begin
        gapNext = gapQ + GAP_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seqQ <= SEQ_IDLE;
      gapQ <= '0;
    end else begin
      seqQ <= seqNext;
      gapQ <= gapNext;
    end
  end

  assign cfgOpen = !doneQ || (openQ != '0);

  // Unlock lifetime and first-configuration latch
  always_ff @(posedge clk) begin
    if (!rstN) begin
      openQ <= '0;
      doneQ <= 1'b0;
    end else begin
      if (unlockHit && cs1Q[CTL_PERM_BIT]) openQ <= OPEN_LD;
      else if (wrCs1)                      openQ <= '0;
      else if (openQ != '0)                openQ <= openQ - OPEN_W'(1);
      if (wrCs1 && cfgOpen) doneQ <= 1'b1;
    end
  end

  // Configuration registers, written only while open
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cs1Q    <= '0;
      clkSelQ <= '0;
      tovQ    <= DEF_TIMEOUT;
      winQ    <= '0;
    end else if (cfgOpen) begin
      if (wrCs1) cs1Q    <= busWdata[7:0];
      if (wrCs2) clkSelQ <= cs2Sel;
      if (wrTov) tovQ    <= busWdata[DW-1:0];
      if (wrWin) winQ    <= busWdata[DW-1:0];
    end
  end

  assign stb.refresh = refreshHit;
  assign stb.flagClr = wrCs2 && cs2Clr;
endmodule

// File: rtl/keyed_wdt_dp.sv
module keyed_wdt_dp
  import keyed_wdt_pkg::*;
#(
  parameter int DW    = 16,
  parameter int NSRC  = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             en,
  input  logic [SEL_W-1:0] clkSel,
  input  logic [NSRC-1:0]  tickEn,
  input  logic [DW-1:0]    tov,
  input  logic [DW-1:0]    win,
  input  ctrl_stb_t        stb,
  output logic [DW-1:0]    cntQ,
  output logic             flagQ,
  output logic             rstReqQ,
  output logic             timeoutHit
);
  logic tickSel, winViol;

  always_comb begin
    tickSel    = tickEn[clkSel];
    timeoutHit = en && (cntQ == tov);
    winViol    = en && stb.refresh && (win != '0) && (cntQ < win);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ    <= '0;
      flagQ   <= 1'b0;
      rstReqQ <= 1'b0;
    end else begin
      rstReqQ <= timeoutHit || winViol;
      if (timeoutHit)                  cntQ <= '0;
      else if (stb.refresh && !winViol) cntQ <= '0;
      else if (en && tickSel)          cntQ <= cntQ + DW'(1);
      if (timeoutHit || winViol) flagQ <= 1'b1;
      else if (stb.flagClr)      flagQ <= 1'b0;
    end
  end
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import keyed_wdt_pkg::*;
#(
  parameter int DW       = 16,
  parameter int NSRC     = 4,
  parameter int SEQ_GAP  = 16,
  parameter int OPEN_CYC = 128,
  parameter logic [DW-1:0] DEF_TIMEOUT = 16'h1500
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            busWr,
  input  logic            busByte,
  input  logic [3:0]      busAddr,
  input  logic [31:0]     busWdata,
  output logic [31:0]     busRdata,
  input  logic [NSRC-1:0] tickEn,
  output logic            rstReq,
  output logic            toFlag
);
  localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [7:0]       cs1Q;
  logic [SEL_W-1:0] clkSelQ;
  logic [DW-1:0]    tovQ, winQ, cntQ;
  logic             cfgOpen, timeoutHit, flagQ;
  ctrl_stb_t        stb;
  logic [7:0]       cs2Rd;

  keyed_wdt_ctrl #(
    .DW(DW), .SEL_W(SEL_W), .SEQ_GAP(SEQ_GAP),
    .OPEN_CYC(OPEN_CYC), .DEF_TIMEOUT(DEF_TIMEOUT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busByte(busByte),
    .busAddr(busAddr), .busWdata(busWdata), .cs1Q(cs1Q),
    .clkSelQ(clkSelQ), .tovQ(tovQ), .winQ(winQ),
    .cfgOpen(cfgOpen), .stb(stb)
  );

  keyed_wdt_dp #(.DW(DW), .NSRC(NSRC), .SEL_W(SEL_W)) u_dp (
    .clk(clk), .rstN(rstN), .en(cs1Q[CTL_EN_BIT]), .clkSel(clkSelQ),
    .tickEn(tickEn), .tov(tovQ), .win(winQ), .stb(stb),
    .cntQ(cntQ), .flagQ(flagQ), .rstReqQ(rstReq), .timeoutHit(timeoutHit)
  );

  always_comb begin
    cs2Rd = '0;
    cs2Rd[SEL_W-1:0]    = clkSelQ;
    cs2Rd[CTL1_FLG_BIT] = flagQ;
    case (busAddr)
      OFS_CTL:  busRdata = {16'h0, cs2Rd, cs1Q};
      OFS_CTL1: busRdata = {24'h0, cs2Rd};
      OFS_CNT:  busRdata = 32'(cntQ);
      OFS_TOV:  busRdata = 32'(tovQ);
      OFS_WIN:  busRdata = 32'(winQ);
      default:  busRdata = '0;
    endcase
  end

  assign toFlag = flagQ;
endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          busWr,
  input logic          busByte,
  input logic [3:0]    busAddr,
  input logic          rstReq,
  input logic          toFlag,
  input logic          en,
  input logic          cfgOpen,
  input logic          refreshStb,
  input logic          flagClr,
  input logic          timeoutHit,
  input logic [DW-1:0] tov,
  input logic [DW-1:0] win,
  input logic [DW-1:0] cnt
);
  // R3
  req_has_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> toFlag);

  // R3
  timeout_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    timeoutHit |=> (rstReq && cnt == '0));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!en && !refreshStb) |=> $stable(cnt));

  // R7
  locked_tov_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !busByte && busAddr == 4'h8 && !cfgOpen) |=> $stable(tov));

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (toFlag && !flagClr) |=> toFlag);

  // R10
  open_refresh_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refreshStb && win == '0 && !timeoutHit) |=> (cnt == '0));
endmodule

bind keyed_wdt keyed_wdt_chk #(.DW(DW)) u_chk (
  .clk(clk), .rstN(rstN), .busWr(busWr), .busByte(busByte),
  .busAddr(busAddr), .rstReq(rstReq), .toFlag(toFlag),
  .en(cs1Q[7]), .cfgOpen(cfgOpen), .refreshStb(stb.refresh),
  .flagClr(stb.flagClr), .timeoutHit(timeoutHit),
  .tov(tovQ), .win(winQ), .cnt(cntQ)
);

// File: tb/keyed_wdt_bench.sv
module keyed_wdt_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWr = 1'b0;
  logic busByte = 1'b0;
  logic [3:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [NSRC-1:0] tickEn = '0;
  logic rstReq, toFlag;

  int nTests = 0;
  int nFail = 0;
  int pulses = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyed_wdt u_keyed_wdt (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busByte(busByte),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .tickEn(tickEn), .rstReq(rstReq), .toFlag(toFlag)
  );

  always @(negedge clk) if (rstReq === 1'b1) pulses <= pulses + 1;

  typedef struct packed {
    logic        wr;
    logic        byt;
    logic [3:0]  addr;
    logic [31:0] data;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 4'h0, 32'h0000_0000},  // R1 control reset value
    '{1'b0, 1'b0, 4'h4, 32'h0000_0000},  // R1 count
    '{1'b0, 1'b0, 4'h8, 32'h0000_1500},  // R1 timeout default
    '{1'b0, 1'b0, 4'hC, 32'h0000_0000},  // R1 window
    '{1'b1, 1'b0, 4'h8, 32'h0000_0005},  // R7 open after reset
    '{1'b0, 1'b0, 4'h8, 32'h0000_0005},
    '{1'b1, 1'b1, 4'h1, 32'h0000_0001},  // R2 select low-power tick
    '{1'b0, 1'b0, 4'h0, 32'h0000_0100},
    '{1'b1, 1'b1, 4'h0, 32'h0000_0080},  // R7 enable, closes config
    '{1'b0, 1'b0, 4'h0, 32'h0000_0180},
    '{1'b1, 1'b0, 4'h8, 32'h0000_0009},  // R7 locked
    '{1'b0, 1'b0, 4'h8, 32'h0000_0005},
    '{1'b1, 1'b1, 4'h1, 32'h0000_0003},  // R7 locked select
    '{1'b0, 1'b0, 4'h0, 32'h0000_0180},
    '{1'b1, 1'b0, 4'hC, 32'h0000_0007},  // R7 locked window
    '{1'b0, 1'b0, 4'hC, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic b);
    @(negedge clk);
    busWr = 1'b1; busByte = b; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0; busByte = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic tick(input int src, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tickEn[src] = 1'b1;
      @(negedge clk);
      tickEn = '0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pair(input logic [31:0] a, input logic [31:0] b);
    wr(4'h4, a, 1'b0);
    wr(4'h4, b, 1'b0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    idle(3);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL R1 watchdog expired: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int p0;
    idle(3);
    rstN = 1'b1;
    idle(1);
    check("R1 rstReq", {31'b0, rstReq}, 32'h0);
    check("R1 flag", {31'b0, toFlag}, 32'h0);

    for (int v = 0; v < NVEC; v++) begin
      if (VECS[v].wr) wr(VECS[v].addr, VECS[v].data, VECS[v].byt);
      else begin
        rd(VECS[v].addr, d);
        check($sformatf("R1/R7 vector %0d", v), d, VECS[v].data);
      end
    end

    // R2: ticks on unselected input do nothing, selected input counts
    tick(0, 3);
    rd(4'h4, d); check("R2 unselected tick", d, 0);
    tick(1, 3);
    rd(4'h4, d); check("R2 selected tick", d, 3);

    // R4 / R10: refresh at non-zero count with window 0
    pair(32'hA602, 32'hB480);
    rd(4'h4, d); check("R4 R10 refresh clears", d, 0);

    // R5: interrupted pair and late second word
    tick(1, 3);
    wr(4'h4, 32'hA602, 1'b0);
    wr(4'h4, 32'h1234, 1'b0);
    wr(4'h4, 32'hB480, 1'b0);
    rd(4'h4, d); check("R5 interrupted pair", d, 3);
    wr(4'h4, 32'hA602, 1'b0);
    idle(20);
    wr(4'h4, 32'hB480, 1'b0);
    rd(4'h4, d); check("R5 late second word", d, 3);
    wr(4'h4, 32'hA602, 1'b0);
    idle(10);
    wr(4'h4, 32'hB480, 1'b0);
    rd(4'h4, d); check("R5 second word in time", d, 0);

    // R3: timeout at 5
    p0 = pulses;
    tick(1, 4);
    check("R3 no early request", {31'b0, rstReq}, 0);
    tick(1, 1);
    rd(4'h4, d); check("R3 count at timeout", d, 5);
    @(negedge clk);
    check("R3 request pulse", {31'b0, rstReq}, 1);
    rd(4'h4, d); check("R3 count cleared", d, 0);
    rd(4'h0, d); check("R3 R6 flag set", d, 32'h4180);
    @(negedge clk);
    check("R3 single pulse", {31'b0, rstReq}, 0);
    idle(1);
    check("R3 pulse count", pulses - p0, 1);

    // R6: write 0 keeps flag, write 1 clears (while locked)
    wr(4'h1, 32'h01, 1'b1);
    rd(4'h0, d); check("R6 write zero keeps flag", d, 32'h4180);
    wr(4'h1, 32'h40, 1'b1);
    rd(4'h0, d); check("R6 write one clears", d, 32'h0180);

    // R8: unlock ignored without permit bit
    pair(32'hC520, 32'hD928);
    wr(4'h8, 32'h7, 1'b0);
    rd(4'h8, d); check("R8 no permit", d, 5);

    // R8: fresh start with permit bit
    doReset();
    rd(4'h0, d); check("R1 after reset", d, 0);
    wr(4'h8, 32'd20, 1'b0);
    wr(4'h1, 32'h01, 1'b1);
    wr(4'h0, 32'hA0, 1'b1);
    wr(4'h8, 32'd25, 1'b0);
    rd(4'h8, d); check("R7 locked after config", d, 20);
    pair(32'hC520, 32'hD928);
    wr(4'h8, 32'd30, 1'b0);
    rd(4'h8, d); check("R8 unlock opens", d, 30);
    wr(4'h0, 32'hA0, 1'b1);
    wr(4'h8, 32'd40, 1'b0);
    rd(4'h8, d); check("R8 control write closes", d, 30);
    pair(32'hC520, 32'hD928);
    idle(100);
    wr(4'h8, 32'd33, 1'b0);
    rd(4'h8, d); check("R8 still open at 100", d, 33);
    pair(32'hC520, 32'hD928);
    idle(130);
    wr(4'h8, 32'd50, 1'b0);
    rd(4'h8, d); check("R8 expired after 128", d, 33);

    // R9: window of 4
    pair(32'hC520, 32'hD928);
    wr(4'hC, 32'd4, 1'b0);
    wr(4'h0, 32'hA0, 1'b1);
    rd(4'hC, d); check("R9 window set", d, 4);
    rd(4'h0, d); check("R9 flag clear before", d, 32'h01A0);
    tick(1, 2);
    pair(32'hA602, 32'hB480);
    check("R9 early refresh request", {31'b0, rstReq}, 1);
    rd(4'h4, d); check("R9 count kept", d, 2);
    rd(4'h0, d); check("R9 flag set", d, 32'h41A0);
    tick(1, 3);
    p0 = pulses;
    pair(32'hA602, 32'hB480);
    check("R9 late refresh no request", {31'b0, rstReq}, 0);
    rd(4'h4, d); check("R9 late refresh clears", d, 0);
    idle(2);
    check("R9 no extra pulse", pulses - p0, 0);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule